// File: doc/BRIEF.md
# Quad Digital Potentiometer Register Core

This block keeps the control state of four 64-position digital potentiometers. A byte-level serial front end supplies it with received bytes and start and stop strobes. Each potentiometer has a 6-bit wiper register and a bank of four 6-bit stored registers. Commands can read or write any of these registers. They can also copy between a wiper and its own stored bank, and step a wiper up or down by one position. Each wiper value drives a one-hot select of 64 taps, which steers a resistor ladder outside this block.

A transaction is a start strobe, then an address byte, then an instruction byte, then one data byte if the command is a write, and then usually a stop strobe. The address byte must carry a fixed device code in its upper nibble and the value of the four strap inputs in its lower nibble. With those straps, sixteen of these devices can share one bus. Read results leave on a byte output together with a one-cycle valid strobe.

Top module: `qdp_core`

## Requirements
- R1: Reset state.
  - Every wiper register and every stored register is 0.
  - Each potentiometer selects only tap 0.
  - `txValid` is low.
- R2: Address matching.
  - The first byte after a start strobe is the address byte.
  - The block acts only if that byte equals {4'b0101, straps}.
  - On any other address byte, every byte up to the next start strobe is ignored.
- R3: Instruction byte layout.
  - Bits [7:4] hold the opcode, bits [3:2] the potentiometer index and bits [1:0] the stored-register index.
  - Opcodes: 9 read wiper, A write wiper, B read stored, C write stored, D recall stored to wiper, E save wiper to stored, 2 increment, 3 decrement.
  - Any other opcode changes nothing and produces no read data.
- R4: Writes.
  - Write-wiper and write-stored take the byte that follows the instruction byte as data.
  - Only data bits [5:0] are stored. Bits [7:6] are ignored.
  - The new value is in place at the clock edge that accepts the data byte.
- R5: Reads.
  - Read-wiper and read-stored set `txValid` for exactly one cycle, starting one clock after the edge that accepts the instruction byte.
  - `txByte` then carries {2'b00, value}.
  - `txValid` is never high at any other time.
- R6: Save and recall.
  - Save copies wiper p into stored register (p, s).
  - Recall copies stored register (p, s) into wiper p.
  - No other potentiometer's registers change.
- R7: Stepping.
  - Increment adds one to wiper p, but a wiper at 63 stays at 63.
  - Decrement subtracts one, but a wiper at 0 stays at 0.
  - Each command moves the wiper by at most one step.
- R8: Tap output.
  - `taps[64*p +: 64]` has exactly one bit set, at the position equal to wiper p.
  - The output follows a wiper change in the same cycle that the register updates.
- R9: Framing.
  - A start strobe or stop strobe in the middle of a command discards the partial command. A start strobe returns the block to waiting for an address byte.
  - Bytes that arrive before any start strobe, after a stop strobe, or after a complete command are ignored until the next start strobe.
  - If a strobe and a byte arrive in the same cycle, the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| straps | input | 4 | Board-level address straps |
| startStb | input | 1 | One-cycle strobe: a bus start condition was seen |
| stopStb | input | 1 | One-cycle strobe: a bus stop condition was seen |
| rxValid | input | 1 | A received byte is on `rxByte` this cycle |
| rxByte | input | 8 | Received byte |
| txValid | output | 1 | One-cycle strobe: read data is on `txByte` |
| txByte | output | 8 | Read data, upper two bits zero |
| taps | output | 256 | One-hot tap selects, 64 per potentiometer, potentiometer 0 in the low bits |

## Verification
The assertions assume the following about the inputs:
- `rxValid`, `startStb` and `stopStb` are single-cycle pulses from the serial front end.
- `straps` changes only while no transaction is in flight.

On those assumptions, the assertions require a read strobe to follow an accepted byte, and the taps to hold still in cycles without a byte. The bench respects the assumptions:
- It drives every strobe for exactly one cycle, between clock edges.
- It changes the straps only between complete transactions.
- It mixes in wrong addresses, unknown opcodes, aborted commands and a strobe coinciding with a byte. It does this only where the requirements define the outcome.

// File: rtl/qdp_pkg.sv
package qdp_pkg;
  localparam int NUM_POTS      = 4;
  localparam int WIPER_W       = 6;
  localparam int SLOTS_PER_POT = 4;
  localparam int STRAP_W       = 4;
  localparam int BYTE_W        = 8;

  localparam int TAPS   = 1 << WIPER_W;
  localparam int POT_W  = $clog2(NUM_POTS);
  localparam int SLOT_W = $clog2(SLOTS_PER_POT);
  localparam int OP_W   = BYTE_W - POT_W - SLOT_W;
  localparam int DEV_W  = BYTE_W - STRAP_W;

  localparam logic [DEV_W-1:0] DEVICE_CODE = DEV_W'(5);

  localparam logic [OP_W-1:0] OP_RD_WIPER = OP_W'(4'h9);
  localparam logic [OP_W-1:0] OP_WR_WIPER = OP_W'(4'hA);
  localparam logic [OP_W-1:0] OP_RD_STORE = OP_W'(4'hB);
  localparam logic [OP_W-1:0] OP_WR_STORE = OP_W'(4'hC);
  localparam logic [OP_W-1:0] OP_RECALL   = OP_W'(4'hD);
  localparam logic [OP_W-1:0] OP_SAVE     = OP_W'(4'hE);
  localparam logic [OP_W-1:0] OP_STEP_UP  = OP_W'(4'h2);
  localparam logic [OP_W-1:0] OP_STEP_DN  = OP_W'(4'h3);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_DONE
  } seqState_t;

  // One-cycle strobes from control to datapath.
  typedef struct packed {
    logic              wrWiper;
    logic              wrStore;
    logic              save;
    logic              recall;
    logic              stepUp;
    logic              stepDn;
    logic              rdWiper;
    logic              rdStore;
    logic [POT_W-1:0]  pot;
    logic [SLOT_W-1:0] slot;
    logic [WIPER_W-1:0] data;
  } ctrlStb_t;
endpackage

// File: rtl/qdp_ctrl.sv
module qdp_ctrl
  import qdp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] straps,
  input  logic               startStb,
  input  logic               stopStb,
  input  logic               rxValid,
  input  logic [BYTE_W-1:0]  rxByte,
  output ctrlStb_t           ctrl
);
  seqState_t         state, nextState;
  logic [OP_W-1:0]   heldOp;
  logic [POT_W-1:0]  heldPot;
  logic [SLOT_W-1:0] heldSlot;

  logic [OP_W-1:0]   rxOp;
  logic [POT_W-1:0]  rxPot;
  logic [SLOT_W-1:0] rxSlot;
  logic              addrHit;

  assign rxOp    = rxByte[BYTE_W-1 -: OP_W];
  assign rxPot   = rxByte[SLOT_W +: POT_W];
  assign rxSlot  = rxByte[SLOT_W-1:0];
  assign addrHit = (rxByte == {DEVICE_CODE, straps});

  always_comb begin
    ctrl      = '0;
    nextState = state;
    if (startStb) begin
      nextState = ST_ADDR;
    end else if (stopStb) begin
      nextState = ST_IDLE;
    end else if (rxValid) begin
      unique case (state)
        ST_ADDR:  nextState = addrHit ? ST_INSTR : ST_DONE;
        ST_INSTR: begin
          ctrl.pot  = rxPot;
          ctrl.slot = rxSlot;
          nextState = ST_DONE;
          unique case (rxOp)
            OP_WR_WIPER, OP_WR_STORE: nextState = ST_DATA;
            OP_RD_WIPER: ctrl.rdWiper = 1'b1;
            OP_RD_STORE: ctrl.rdStore = 1'b1;
            OP_RECALL:   ctrl.recall  = 1'b1;
            OP_SAVE:     ctrl.save    = 1'b1;
            OP_STEP_UP:  ctrl.stepUp  = 1'b1;
            OP_STEP_DN:  ctrl.stepDn  = 1'b1;
            default: ;
          endcase
        end
        ST_DATA: begin
          ctrl.pot     = heldPot;
          ctrl.slot    = heldSlot;
          ctrl.data    = rxByte[WIPER_W-1:0];
          ctrl.wrWiper = (heldOp == OP_WR_WIPER);
          ctrl.wrStore = (heldOp == OP_WR_STORE);
          nextState    = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      heldOp   <= '0;
      heldPot  <= '0;
      heldSlot <= '0;
    end else begin
      state <= nextState;
      if (state == ST_INSTR && rxValid) begin
        heldOp   <= rxOp;
        heldPot  <= rxPot;
        heldSlot <= rxSlot;
      end
    end
  end
endmodule

// File: rtl/qdp_datapath.sv
module qdp_datapath
  import qdp_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStb_t                          ctrl,
  output logic [NUM_POTS-1:0][WIPER_W-1:0]  wipers,
  output logic                              txValid,
  output logic [BYTE_W-1:0]                 txByte
);
  localparam logic [WIPER_W-1:0] WIPER_MAX = '1;
  localparam logic [WIPER_W-1:0] WIPER_MIN = '0;

  logic [NUM_POTS-1:0][SLOTS_PER_POT-1:0][WIPER_W-1:0] store;
  logic [WIPER_W-1:0] curWiper;
  logic [WIPER_W-1:0] curStore;

  assign curWiper = wipers[ctrl.pot];
  assign curStore = store[ctrl.pot][ctrl.slot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wipers  <= '0;
      store   <= '0;
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= ctrl.rdWiper | ctrl.rdStore;
      if (ctrl.rdWiper)      txByte <= BYTE_W'(curWiper);
      else if (ctrl.rdStore) txByte <= BYTE_W'(curStore);

      if (ctrl.wrWiper) wipers[ctrl.pot] <= ctrl.data;
      if (ctrl.recall)  wipers[ctrl.pot] <= curStore;
      if (ctrl.stepUp && curWiper != WIPER_MAX) wipers[ctrl.pot] <= curWiper + 1'b1;
      if (ctrl.stepDn && curWiper != WIPER_MIN) wipers[ctrl.pot] <= curWiper - 1'b1;

      if (ctrl.wrStore) store[ctrl.pot][ctrl.slot] <= ctrl.data;
      if (ctrl.save)    store[ctrl.pot][ctrl.slot] <= curWiper;
    end
  end
endmodule

// File: rtl/qdp_tapdec.sv
module qdp_tapdec #(
  parameter int SEL_W = 6
) (
  input  logic [SEL_W-1:0]        sel,
  output logic [(1<<SEL_W)-1:0]   onehot
);
  always_comb begin
    onehot      = '0;
    onehot[sel] = 1'b1;
  end
endmodule

// File: rtl/qdp_core.sv
module qdp_core
  import qdp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [STRAP_W-1:0]        straps,
  input  logic                      startStb,
  input  logic                      stopStb,
  input  logic                      rxValid,
  input  logic [BYTE_W-1:0]         rxByte,
  output logic                      txValid,
  output logic [BYTE_W-1:0]         txByte,
  output logic [NUM_POTS*TAPS-1:0]  taps
);
  ctrlStb_t ctrl;
  logic [NUM_POTS-1:0][WIPER_W-1:0] wipers;

  qdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .straps(straps),
    .startStb(startStb), .stopStb(stopStb),
    .rxValid(rxValid), .rxByte(rxByte), .ctrl(ctrl)
  );

  qdp_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .wipers(wipers), .txValid(txValid), .txByte(txByte)
  );

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_tap
    qdp_tapdec #(.SEL_W(WIPER_W)) u_dec (
      .sel(wipers[p]),
      .onehot(taps[p*TAPS +: TAPS])
    );
  end
endmodule

// File: rtl/qdp_checker.sv
module qdp_checker
  import qdp_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     startStb,
  input logic                     stopStb,
  input logic                     rxValid,
  input logic                     txValid,
  input logic [BYTE_W-1:0]        txByte,
  input logic [NUM_POTS*TAPS-1:0] taps
);
  for (genvar p = 0; p < NUM_POTS; p++) begin : g_chk
    p_tap_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
      $countones(taps[p*TAPS +: TAPS]) == 1);
  end

  p_tx_after_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(rxValid));

  p_tx_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txByte[BYTE_W-1:WIPER_W] == '0));

  p_strobe_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (startStb || stopStb) |=> !txValid);

  p_taps_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(taps));
endmodule

bind qdp_core qdp_checker u_chk (
  .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
  .rxValid(rxValid), .txValid(txValid), .txByte(txByte), .taps(taps)
);

// File: tb/tb_qdp_core.sv
module tb_qdp_core;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   straps = 4'b1011;
  logic         startStb = 1'b0;
  logic         stopStb = 1'b0;
  logic         rxValid = 1'b0;
  logic [7:0]   rxByte = 8'h00;
  logic         txValid;
  logic [7:0]   txByte;
  logic [255:0] taps;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit doneFlag = 0;

  logic [5:0] mWiper [4];
  logic [5:0] mStore [4][4];

  localparam logic [3:0] RDW = 4'h9, WRW = 4'hA, RDS = 4'hB, WRS = 4'hC,
                         RCL = 4'hD, SAV = 4'hE, INC = 4'h2, DEC = 4'h3;

  qdp_core dut (
    .clk(clk), .rstN(rstN), .straps(straps), .startStb(startStb),
    .stopStb(stopStb), .rxValid(rxValid), .rxByte(rxByte),
    .txValid(txValid), .txByte(txByte), .taps(taps)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !doneFlag) begin
      nFails = nFails + 1;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    startStb = 1'b1; @(negedge clk); startStb = 1'b0;
  endtask

  task automatic pulseStop();
    stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1'b1; rxByte = b; @(negedge clk); rxValid = 1'b0;
  endtask

  function automatic bit isWrite(input logic [3:0] op);
    return (op == WRW) || (op == WRS);
  endfunction

  function automatic bit isRead(input logic [3:0] op);
    return (op == RDW) || (op == RDS);
  endfunction

  function automatic logic [5:0] expRead(input logic [3:0] op, input int p, input int s);
    return (op == RDW) ? mWiper[p] : mStore[p][s];
  endfunction

  function automatic void applyModel(input logic [3:0] op, input int p, input int s,
                                     input logic [7:0] d);
    case (op)
      WRW: mWiper[p] = d[5:0];
      WRS: mStore[p][s] = d[5:0];
      RCL: mWiper[p] = mStore[p][s];
      SAV: mStore[p][s] = mWiper[p];
      INC: if (mWiper[p] != 6'd63) mWiper[p] = mWiper[p] + 6'd1;
      DEC: if (mWiper[p] != 6'd0)  mWiper[p] = mWiper[p] - 6'd1;
      default: ;
    endcase
  endfunction

  task automatic checkTaps(input string req);
    for (int p = 0; p < 4; p++) begin
      logic [63:0] exp, act;
      exp = 64'd1 << mWiper[p];
      act = taps[p*64 +: 64];
      check(act == exp, req, $sformatf("taps pot%0d", p), act, exp);
    end
  endtask

  task automatic doCmd(input logic [7:0] addr, input logic [3:0] op, input int p,
                       input int s, input logic [7:0] d,
                       output logic gotV, output logic [7:0] got);
    pulseStart();
    sendByte(addr);
    sendByte({op, 2'(p), 2'(s)});
    gotV = txValid; got = txByte;
    if (isWrite(op)) sendByte(d);
    pulseStop();
  endtask

  function automatic logic [7:0] myAddr();
    return {4'b0101, straps};
  endfunction

  task automatic readBack(input logic [3:0] op, input int p, input int s, input string req);
    logic v; logic [7:0] g;
    doCmd(myAddr(), op, p, s, 8'h00, v, g);
    check(v == 1'b1, req, "read txValid", 64'(v), 64'd1);
    check(g == {2'b00, expRead(op, p, s)}, req, "read data", 64'(g),
          64'({2'b00, expRead(op, p, s)}));
  endtask

  logic [3:0] opList [8];

  initial begin
    logic v; logic [7:0] g;
    opList = '{RDW, WRW, RDS, WRS, RCL, SAV, INC, DEC};
    for (int p = 0; p < 4; p++) begin
      mWiper[p] = '0;
      for (int s = 0; s < 4; s++) mStore[p][s] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(txValid == 1'b0, "R1", "txValid after reset", 64'(txValid), 64'd0);
    checkTaps("R1");
    readBack(RDS, 2, 3, "R1");
    readBack(RDW, 3, 0, "R1");

    // R4 write with upper bits set, R8 tap follows
    doCmd(myAddr(), WRW, 1, 0, 8'hFF, v, g); applyModel(WRW, 1, 0, 8'hFF);
    check(mWiper[1] == 6'd63, "R4", "model upper bits", 64'(mWiper[1]), 64'd63);
    checkTaps("R8");
    readBack(RDW, 1, 0, "R5");
    doCmd(myAddr(), WRS, 0, 3, 8'hAA, v, g); applyModel(WRS, 0, 3, 8'hAA);
    readBack(RDS, 0, 3, "R4");

    // R7 saturation
    doCmd(myAddr(), INC, 1, 0, 8'h00, v, g); applyModel(INC, 1, 0, 8'h00);
    checkTaps("R7");
    doCmd(myAddr(), DEC, 2, 0, 8'h00, v, g); applyModel(DEC, 2, 0, 8'h00);
    checkTaps("R7");
    check(v == 1'b0, "R5", "no txValid on step", 64'(v), 64'd0);

    // R6 save then recall within own pot only
    doCmd(myAddr(), SAV, 1, 2, 8'h00, v, g); applyModel(SAV, 1, 2, 8'h00);
    doCmd(myAddr(), WRW, 1, 0, 8'h05, v, g); applyModel(WRW, 1, 0, 8'h05);
    doCmd(myAddr(), RCL, 1, 2, 8'h00, v, g); applyModel(RCL, 1, 2, 8'h00);
    checkTaps("R6");
    readBack(RDS, 0, 2, "R6");
    readBack(RDS, 2, 2, "R6");
    readBack(RDS, 1, 2, "R6");

    // R2 wrong straps and wrong device code
    doCmd({4'b0101, ~straps}, WRW, 0, 0, 8'h11, v, g);
    checkTaps("R2");
    doCmd({4'b0110, straps}, WRW, 0, 0, 8'h12, v, g);
    checkTaps("R2");
    check(v == 1'b0, "R2", "no read on miss", 64'(v), 64'd0);

    // R3 unknown opcode
    doCmd(myAddr(), 4'h7, 0, 0, 8'h00, v, g);
    check(v == 1'b0, "R3", "unknown opcode txValid", 64'(v), 64'd0);
    checkTaps("R3");

    // R9 abort by stop before data byte, then stray data byte
    pulseStart(); sendByte(myAddr()); sendByte({WRW, 2'd3, 2'd0});
    pulseStop(); sendByte(8'h2A);
    checkTaps("R9");
    // R9 abort by restart mid-command, then full new command
    pulseStart(); sendByte(myAddr()); sendByte({WRW, 2'd3, 2'd0});
    pulseStart(); sendByte(myAddr()); sendByte({INC, 2'd3, 2'd0});
    sendByte({INC, 2'd3, 2'd0}); pulseStop();
    applyModel(INC, 3, 0, 8'h00);
    checkTaps("R9");
    // R9 byte arriving with a strobe is dropped
    pulseStart(); sendByte(myAddr());
    startStb = 1'b1; rxValid = 1'b1; rxByte = {INC, 2'd0, 2'd0};
    @(negedge clk); startStb = 1'b0; rxValid = 1'b0;
    sendByte({4'h0, 4'h0}); pulseStop();
    checkTaps("R9");
    // R9 bytes before any start are ignored
    sendByte(myAddr()); sendByte({INC, 2'd0, 2'd0});
    checkTaps("R9");
    check(txValid == 1'b0, "R9", "txValid idle", 64'(txValid), 64'd0);

    // R2 new strap value
    straps = 4'b0110;
    @(negedge clk);
    doCmd(myAddr(), WRW, 0, 0, 8'h21, v, g); applyModel(WRW, 0, 0, 8'h21);
    checkTaps("R2");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      int p, s;
      logic [7:0] d, addr;
      bit miss;
      op = opList[$urandom_range(7)];
      p = $urandom_range(3);
      s = $urandom_range(3);
      d = 8'($urandom);
      miss = ($urandom_range(9) == 0);
      addr = miss ? {4'b0101, straps ^ 4'(1 + $urandom_range(14))} : myAddr();
      doCmd(addr, op, p, s, d, v, g);
      if (!miss) begin
        if (isRead(op)) begin
          check(v == 1'b1, "R5", "rand read valid", 64'(v), 64'd1);
          check(g == {2'b00, expRead(op, p, s)}, "R5", "rand read data", 64'(g),
                64'({2'b00, expRead(op, p, s)}));
        end else begin
          check(v == 1'b0, "R3", "rand no read", 64'(v), 64'd0);
        end
        applyModel(op, p, s, d);
      end else begin
        check(v == 1'b0, "R2", "rand miss no read", 64'(v), 64'd0);
      end
      checkTaps((op == INC || op == DEC) ? "R7" : "R6");
    end

    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule